// File: doc/BRIEF.md
# PCI Function Configuration Register Space

This block is the target side of the configuration register space for a single PCI function. Configuration software reaches it through a simple request/response port. Each request names one of 64 dword locations, which together cover 256 bytes. It carries a read/write flag, four byte enables and write data. The block answers exactly one cycle later with a response strobe, a retry flag and read data. The lower 16 dwords hold the standard header. Device-specific registers sit at dword 16 and above. Every location without a register reads as zero, and a write to it is dropped.

The header reports the identity values. Two of these, the Subsystem Vendor ID and the Subsystem ID, are not fixed at build time. After reset, a loader reads them from an external serial EEPROM over a four-wire SPI link. The link runs in mode 0 and sends the most significant bit first. Until that read finishes, every configuration access gets a retry answer and changes nothing. If the word read back holds a zero field, or reads as all ones (no device on the line), the loader substitutes non-zero defaults and raises an error flag.

Top module: `cfgspace_top`

## Requirements
- R1: While reset is held, `spi_cs_n` is 1, and `load_done`, `load_err` and `rsp_valid` are 0.
- R2: After reset, the loader lowers `spi_cs_n` and runs one mode-0 SPI transfer. It shifts out 16 bits MSB first: opcode 03h, then the ROM word address (parameter, default 10h). It then shifts in 32 bits MSB first on the rising edges of `spi_sck`. Afterwards it raises `spi_cs_n` and asserts `load_done`, which stays high until reset.
- R3: An access presented while `load_done` is 0 is answered with `rsp_retry`=1 and `rsp_rdata`=0, and no register changes. An access presented while `load_done` is 1 is answered with `rsp_retry`=0.
- R4: Every request cycle produces `rsp_valid` for exactly one cycle, one clock later. A write response carries `rsp_rdata`=0.
- R5: Dword 11 (byte offset 2Ch) reads as {Subsystem ID, Subsystem Vendor ID}. The Subsystem ID is the upper 16 bits of the ROM word, and the Vendor ID is the lower 16 bits. The dword is read-only.
- R6: If the ROM word has a zero upper half, a zero lower half, or is all ones, dword 11 reads {DEF_SSID, DEF_SSVID} (default 0001_1ABCh) and `load_err` is 1. Otherwise `load_err` is 0.
- R7: Dword 0 reads {Device ID, Vendor ID}. Dword 2 reads {class code, revision}. Dword 3 carries the header type in bits 23:16. All three are read-only.
- R8: In dword 1, bits 15:0 form the command register. Only the bits set in CMD_WMASK (default 0547h) can be written. All other bits of the dword read as 0.
- R9: Dword 15 (byte offset 3Ch) holds the read/write interrupt line in bits 7:0 and the constant interrupt pin in bits 15:8 (default 01h). Bits 31:16 read as 0.
- R10: A write changes only the bytes whose enable bit is 1. Enable bit n covers data bits 8n+7:8n.
- R11: Dword 16 (byte offset 40h) is a 32-bit device-specific read/write register with a reset value of 0.
- R12: Reads of any other dword return 0. Writes to them complete normally and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Dword index into the 256-byte space |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_retry | output | 1 | Access refused because the ROM load has not finished |
| rsp_rdata | output | 32 | Read data |
| spi_cs_n | output | 1 | Serial ROM chip select, active low |
| spi_sck | output | 1 | Serial ROM clock |
| spi_mosi | output | 1 | Serial data to the ROM |
| spi_miso | input | 1 | Serial data from the ROM |
| load_done | output | 1 | Subsystem IDs are valid |
| load_err | output | 1 | Defaults were substituted for the ROM word |

## Verification
The completion of the ROM load and the arrival of a configuration request can land in the same clock edge. That edge decides whether the request is refused or served. The bench waits until its ROM model has seen the last data bit. It then issues a read on every cycle across the moment `load_done` rises. For each response, it expects a retry exactly when `load_done` was low during the request cycle, and otherwise the identity data. It also checks that both kinds of answer occurred within that window.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    // Serial ROM loader sequencing
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_FIN   = 2'd2
    } ld_state_e;

    localparam logic [7:0] ROM_READ_OP = 8'h03;
    localparam int         CMD_BITS    = 16;
    localparam int         DATA_BITS   = 32;
endpackage

// File: rtl/sprom_loader.sv
module sprom_loader
    import cfg_pkg::*;
#(
    parameter int          HALF_PERIOD = 4,
    parameter logic [7:0]  ROM_ADDR    = 8'h10,
    parameter logic [15:0] DEF_SSID    = 16'h0001,
    parameter logic [15:0] DEF_SSVID   = 16'h1ABC
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        done,
    output logic        err,
    output logic [15:0] ssid,
    output logic [15:0] ssvid
);
    localparam int TOTAL_BITS = CMD_BITS + DATA_BITS;
    localparam int DIV_W      = $clog2(HALF_PERIOD + 1);
    localparam int BIT_W      = $clog2(TOTAL_BITS + 1);

    typedef struct packed {
        ld_state_e              st;
        logic [DIV_W-1:0]       div;
        logic [BIT_W-1:0]       bitn;
        logic                   sck;
        logic                   cs_n;
        logic [CMD_BITS-1:0]    cmd_sr;
        logic [DATA_BITS-1:0]   data_sr;
        logic                   done;
        logic                   err;
        logic [15:0]            ssid;
        logic [15:0]            ssvid;
    } ld_t;

    ld_t  q, d;
    logic bad_word;

    assign bad_word = (q.data_sr[31:16] == 16'h0) || (q.data_sr[15:0] == 16'h0)
                    || (&q.data_sr);

    always_comb begin
        d = q;
        case (q.st)
            LD_IDLE: begin
                d.st     = LD_SHIFT;
                d.cs_n   = 1'b0;
                d.sck    = 1'b0;
                d.div    = '0;
                d.bitn   = '0;
                d.cmd_sr = {ROM_READ_OP, ROM_ADDR};
            end
            LD_SHIFT: begin
                if (q.div == DIV_W'(HALF_PERIOD - 1)) begin
                    d.div = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        if (q.bitn >= BIT_W'(CMD_BITS))
                            d.data_sr = {q.data_sr[DATA_BITS-2:0], spi_miso};
                    end else begin
                        d.sck    = 1'b0;
                        d.cmd_sr = {q.cmd_sr[CMD_BITS-2:0], 1'b0};
                        if (q.bitn == BIT_W'(TOTAL_BITS - 1))
                            d.st = LD_FIN;
                        else
                            d.bitn = q.bitn + BIT_W'(1);
                    end
                end else begin
                    d.div = q.div + DIV_W'(1);
                end
            end
            LD_FIN: begin
                if (!q.done) begin
                    d.cs_n  = 1'b1;
                    d.done  = 1'b1;
                    d.err   = bad_word;
                    d.ssid  = bad_word ? DEF_SSID  : q.data_sr[31:16];
                    d.ssvid = bad_word ? DEF_SSVID : q.data_sr[15:0];
                end
            end
            default: d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign spi_cs_n = q.cs_n;
    assign spi_sck  = q.sck;
    assign spi_mosi = q.cmd_sr[CMD_BITS-1];
    assign done     = q.done;
    assign err      = q.err;
    assign ssid     = q.ssid;
    assign ssvid    = q.ssvid;

    assert_cs_released_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    assert_sck_low_when_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_ids_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ssid != 16'h0) && (ssvid != 16'h0));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
    parameter int          SPACE_BYTES = 256,
    parameter logic [15:0] VENDOR_ID   = 16'h1ABC,
    parameter logic [15:0] DEVICE_ID   = 16'h0042,
    parameter logic [23:0] CLASS_CODE  = 24'h058000,
    parameter logic [7:0]  REVISION    = 8'h01,
    parameter logic [7:0]  HDR_TYPE    = 8'h00,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [15:0] CMD_WMASK   = 16'h0547,
    localparam int         ADDR_W      = $clog2(SPACE_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [15:0]       ssid,
    input  logic [15:0]       ssvid,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [31:0]       rsp_rdata
);
    localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLASS   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HDR     = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_SUBSYS  = ADDR_W'(11);
    localparam logic [ADDR_W-1:0] A_INTR    = ADDR_W'(15);
    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(16);

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  int_line;
        logic [31:0] scratch;
        logic        rsp_valid;
        logic        rsp_retry;
        logic [31:0] rsp_rdata;
    } regs_t;

    regs_t       q, d;
    logic [31:0] rd_word;
    logic        wr_ok;

    always_comb begin
        case (req_addr)
            A_ID:      rd_word = {DEVICE_ID, VENDOR_ID};
            A_CMD:     rd_word = {16'h0, q.cmd};
            A_CLASS:   rd_word = {CLASS_CODE, REVISION};
            A_HDR:     rd_word = {8'h00, HDR_TYPE, 16'h0};
            A_SUBSYS:  rd_word = {ssid, ssvid};
            A_INTR:    rd_word = {16'h0, INT_PIN, q.int_line};
            A_SCRATCH: rd_word = q.scratch;
            default:   rd_word = '0;
        endcase
    end

    assign wr_ok = req_valid && req_write && ready;

    always_comb begin
        d = q;
        d.rsp_valid = req_valid;
        d.rsp_retry = req_valid && !ready;
        d.rsp_rdata = (req_valid && !req_write && ready) ? rd_word : 32'h0;
        if (wr_ok) begin
            case (req_addr)
                A_CMD: begin
                    for (int b = 0; b < 2; b++)
                        if (req_be[b])
                            d.cmd[b*8 +: 8] = req_wdata[b*8 +: 8] & CMD_WMASK[b*8 +: 8];
                end
                A_INTR: if (req_be[0]) d.int_line = req_wdata[7:0];
                A_SCRATCH: begin
                    for (int b = 0; b < 4; b++)
                        if (req_be[b]) d.scratch[b*8 +: 8] = req_wdata[b*8 +: 8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_retry = q.rsp_retry;
    assign rsp_rdata = q.rsp_rdata;

    assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_retry_until_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ready) |=> (rsp_retry && rsp_rdata == 32'h0));
    assert_served_when_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !rsp_retry);
    assert_frozen_until_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(q.cmd) && $stable(q.int_line) && $stable(q.scratch)));
    assert_subsys_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ($stable(ssid) && $stable(ssvid)));
endmodule

// File: rtl/cfgspace_top.sv
module cfgspace_top #(
    parameter int          SPACE_BYTES = 256,
    parameter logic [15:0] VENDOR_ID   = 16'h1ABC,
    parameter logic [15:0] DEVICE_ID   = 16'h0042,
    parameter logic [23:0] CLASS_CODE  = 24'h058000,
    parameter logic [7:0]  REVISION    = 8'h01,
    parameter logic [7:0]  HDR_TYPE    = 8'h00,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [15:0] CMD_WMASK   = 16'h0547,
    parameter int          HALF_PERIOD = 4,
    parameter logic [7:0]  ROM_ADDR    = 8'h10,
    parameter logic [15:0] DEF_SSID    = 16'h0001,
    parameter logic [15:0] DEF_SSVID   = 16'h1ABC,
    localparam int         ADDR_W      = $clog2(SPACE_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [31:0]       rsp_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              load_done,
    output logic              load_err
);
    logic [15:0] ssid_w, ssvid_w;

    sprom_loader #(
        .HALF_PERIOD (HALF_PERIOD),
        .ROM_ADDR    (ROM_ADDR),
        .DEF_SSID    (DEF_SSID),
        .DEF_SSVID   (DEF_SSVID)
    ) loader_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .done     (load_done),
        .err      (load_err),
        .ssid     (ssid_w),
        .ssvid    (ssvid_w)
    );

    cfg_regs #(
        .SPACE_BYTES (SPACE_BYTES),
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .CLASS_CODE  (CLASS_CODE),
        .REVISION    (REVISION),
        .HDR_TYPE    (HDR_TYPE),
        .INT_PIN     (INT_PIN),
        .CMD_WMASK   (CMD_WMASK)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (load_done),
        .ssid      (ssid_w),
        .ssvid     (ssvid_w),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_retry (rsp_retry),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: tb/cfgspace_top_tb_top.sv
module cfgspace_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_retry;
    logic [31:0] rsp_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;
    logic        load_done, load_err;

    int checks = 0;
    int fails  = 0;

    // ROM model state
    logic [31:0] rom_word = 32'hBEEF_CAFE;
    logic        rom_present = 1'b1;
    int          rise_cnt = 0;
    logic [15:0] cmd_seen = '0;

    logic        r_valid, r_retry;
    logic [31:0] r_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgspace_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .load_done(load_done), .load_err(load_err)
    );

    // Mode-0 serial ROM: command sampled on rising SCK, data driven after falling SCK
    always @(negedge spi_cs_n) rise_cnt = 0;
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (rise_cnt < 16) cmd_seen = {cmd_seen[14:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        if (rise_cnt >= 16 && rise_cnt < 48)
            spi_miso = rom_present ? rom_word[47 - rise_cnt] : 1'b1;
    end

    // Vector: {tag, wr, addr, be, wdata, expected read data}
    localparam logic [78:0] VEC [NV] = '{
        {4'd7,  1'b0, 6'd0,  4'h0, 32'h0,         32'h0042_1ABC}, // R7 ids
        {4'd7,  1'b0, 6'd2,  4'h0, 32'h0,         32'h0580_0001}, // R7 class/rev
        {4'd7,  1'b0, 6'd3,  4'h0, 32'h0,         32'h0000_0000}, // R7 header type
        {4'd5,  1'b0, 6'd11, 4'h0, 32'h0,         32'hBEEF_CAFE}, // R5 subsystem
        {4'd5,  1'b1, 6'd11, 4'hF, 32'h0,         32'h0},         // R5 write to read-only
        {4'd5,  1'b0, 6'd11, 4'h0, 32'h0,         32'hBEEF_CAFE}, // R5 unchanged
        {4'd8,  1'b0, 6'd1,  4'h0, 32'h0,         32'h0},         // R8 reset value
        {4'd8,  1'b1, 6'd1,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R8 write all ones
        {4'd8,  1'b0, 6'd1,  4'h0, 32'h0,         32'h0000_0547}, // R8 masked
        {4'd10, 1'b1, 6'd1,  4'h2, 32'h0,         32'h0},         // R10 clear byte 1
        {4'd10, 1'b0, 6'd1,  4'h0, 32'h0,         32'h0000_0047}, // R10
        {4'd9,  1'b0, 6'd15, 4'h0, 32'h0,         32'h0000_0100}, // R9 pin, line 0
        {4'd9,  1'b1, 6'd15, 4'hF, 32'hFFFF_FF0B, 32'h0},         // R9 write line
        {4'd9,  1'b0, 6'd15, 4'h0, 32'h0,         32'h0000_010B}, // R9
        {4'd10, 1'b1, 6'd15, 4'hE, 32'h0000_00FF, 32'h0},         // R10 byte 0 off
        {4'd10, 1'b0, 6'd15, 4'h0, 32'h0,         32'h0000_010B}, // R10 unchanged
        {4'd10, 1'b1, 6'd16, 4'h5, 32'hAABB_CCDD, 32'h0},         // R10 bytes 0,2
        {4'd11, 1'b0, 6'd16, 4'h0, 32'h0,         32'h00BB_00DD}, // R11
        {4'd11, 1'b1, 6'd16, 4'hA, 32'h1122_3344, 32'h0},         // R11 bytes 1,3
        {4'd11, 1'b0, 6'd16, 4'h0, 32'h0,         32'h11BB_33DD}, // R11
        {4'd12, 1'b0, 6'd4,  4'h0, 32'h0,         32'h0},         // R12 unimplemented
        {4'd12, 1'b1, 6'd20, 4'hF, 32'h1234_5678, 32'h0},         // R12 write dropped
        {4'd12, 1'b0, 6'd20, 4'h0, 32'h0,         32'h0},         // R12 reads zero
        {4'd12, 1'b0, 6'd63, 4'h0, 32'h0,         32'h0},         // R12 top dword
        {4'd7,  1'b1, 6'd0,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R7 write to ids
        {4'd7,  1'b0, 6'd0,  4'h0, 32'h0,         32'h0042_1ABC}  // R7 unchanged
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [5:0] a, input logic [3:0] be,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(negedge clk);
        r_valid = rsp_valid; r_retry = rsp_retry; r_data = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset(input logic [31:0] word, input logic present);
        @(negedge clk);
        rst_n = 1'b0;
        rom_word = word; rom_present = present; spi_miso = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", {31'h0, spi_cs_n}, 32'h1);
        chk("R1 done/err/rsp in reset", {29'h0, load_done, load_err, rsp_valid}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic wait_loaded();
        while (!load_done) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [78:0] v;
        int retries, served;
        logic prev_done;

        // Good ROM word
        do_reset(32'hBEEF_CAFE, 1'b1);

        // R3: accesses during the load are refused and change nothing
        access(1'b1, 6'd15, 4'hF, 32'h0000_0055);
        chk("R3 retry on write during load", {30'h0, r_valid, r_retry}, 32'h3);
        access(1'b1, 6'd16, 4'hF, 32'hDEAD_BEEF);
        access(1'b0, 6'd0, 4'h0, 32'h0);
        chk("R3 retry on read during load", {30'h0, r_valid, r_retry}, 32'h3);
        chk("R3 retry data zero", r_data, 32'h0);

        // Collision of load completion with streaming requests (R3)
        while (rise_cnt < 47) @(negedge clk);
        retries = 0; served = 0; prev_done = 1'b0;
        for (int i = 0; i < 41; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R3 retry matches load state", {31'h0, rsp_retry}, {31'h0, !prev_done});
                chk("R4 response per request", {31'h0, rsp_valid}, 32'h1);
                if (prev_done) begin
                    served++;
                    chk("R7 served read at completion", rsp_rdata, 32'h0042_1ABC);
                end else retries++;
            end
            prev_done = load_done;
            req_valid = (i < 40); req_write = 1'b0; req_addr = 6'd0; req_be = 4'h0;
        end
        chk("R3 both outcomes seen", {30'h0, retries > 0, served > 0}, 32'h3);

        // R2: transfer shape and completion
        chk("R2 command bits", {16'h0, cmd_seen}, 32'h0000_0310);
        chk("R2 rising edges", rise_cnt, 48);
        chk("R2 cs released, done", {30'h0, spi_cs_n, load_done}, 32'h3);
        chk("R6 no error for good word", {31'h0, load_err}, 32'h0);

        // R3: writes issued during load left no trace
        access(1'b0, 6'd15, 4'h0, 32'h0);
        chk("R3 int line untouched", r_data, 32'h0000_0100);
        access(1'b0, 6'd16, 4'h0, 32'h0);
        chk("R3 scratch untouched", r_data, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            access(v[74], v[73:68], v[67:64], v[63:32]);
            if (!(r_valid === 1'b1 && r_retry === 1'b0)) begin
                checks++; fails++;
                $display("FAIL R4 vector %0d: actual valid=%b retry=%b expected valid=1 retry=0",
                         i, r_valid, r_retry);
            end else begin
                checks++;
                if (r_data !== v[31:0]) begin
                    fails++;
                    $display("FAIL R%0d vector %0d: actual=%h expected=%h",
                             v[78:75], i, r_data, v[31:0]);
                end
            end
        end

        // R4: single-cycle response
        @(negedge clk);
        chk("R4 response drops after one cycle", {31'h0, rsp_valid}, 32'h0);

        // R6: zero Vendor field
        do_reset(32'h1234_0000, 1'b1);
        wait_loaded();
        chk("R6 error on zero field", {31'h0, load_err}, 32'h1);
        access(1'b0, 6'd11, 4'h0, 32'h0);
        chk("R6 defaults on zero field", r_data, 32'h0001_1ABC);
        access(1'b0, 6'd1, 4'h0, 32'h0);
        chk("R1 command cleared by reset", r_data, 32'h0);

        // R6: zero Subsystem ID field
        do_reset(32'h0000_5678, 1'b1);
        wait_loaded();
        access(1'b0, 6'd11, 4'h0, 32'h0);
        chk("R6 defaults on zero ID", r_data, 32'h0001_1ABC);

        // R6: absent ROM reads all ones
        do_reset(32'h0, 1'b0);
        wait_loaded();
        chk("R6 error on absent ROM", {31'h0, load_err}, 32'h1);
        access(1'b0, 6'd11, 4'h0, 32'h0);
        chk("R6 defaults on absent ROM", r_data, 32'h0001_1ABC);

        summary();
        $finish;
    end
endmodule